// File: doc/BRIEF.md
# RF Register Command Mailbox Issuer

This block turns one host request for an RF register access into a command word and hands it to a separate controller through a 32-bit command mailbox. A request carries a direction, a 2-bit radio path, an 8-bit RF register address and, for a write, 12 bits of data. The block first polls the mailbox until its busy bit clears, then writes the packed command with the trigger bit set. For a read, it then polls the mailbox again until the controller has finished, and fetches the result from a separate data register.

Polling is bounded. There is one retry budget per request, and a read draws on it in both of its polling phases. A write whose pre-issue poll runs out of budget is still issued. A read that runs out of budget while it waits for completion returns zero. Each request ends with a one-cycle completion pulse. The pulse carries the read result and a flag that reports whether any polling phase ran out of budget.

The mailbox and the data register sit behind a simple register port. Read data on that port is combinational and valid in the same cycle as the read strobe. Only one request is in flight at a time, and it is accepted with a valid/ready handshake.

Top module: `rf_mbox_issuer`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, and `done`, `reg_rd_en` and `reg_wr_en` are all 0.
- R2: Every mailbox write carries this command word: bit 31 = 1 (trigger), bits 30:23 = 0, bits 21:20 = path, bits 19:12 = register address, and `reg_sel` = 0 (mailbox).
- R3: Bit 22 of the command word is 1 for a write and 0 for a read. Bits 11:0 hold the write data for a write and are 0 for a read.
- R4: A request is accepted only while `req_ready` is 1. `req_ready` is 0 from the cycle after acceptance until the request completes.
- R5: The mailbox busy flag is bit 31 of a mailbox read. After each busy observation that still has budget, the retry count rises by one and the next mailbox read comes at least POLL_GAP cycles later. The number of mailbox reads per request follows from the busy observations and the budget, as laid out in R6 and R8.
- R6: If a busy observation occurs while the retry count already equals POLL_LIMIT before issue, the command is written anyway. For a write, the completion then reports timeout = 1 and data 0. A write that was not forced reports timeout = 0 and data 0.
- R7: For a read, once a post-issue mailbox read shows bit 31 clear, the data register (`reg_sel` = 1) is read. Its full 32-bit value is returned with `done`. The timeout flag is 1 only if the pre-issue phase ran out of budget.
- R8: A read uses one retry count across both phases. A busy observation after issue, made while the count equals POLL_LIMIT, ends the request with data 0 and timeout = 1, and the data register is not read.
- R9: Each request produces exactly one mailbox write and exactly one `done` pulse, one cycle long.
- R10: `reg_rd_en` and `reg_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_path | input | 2 | Radio path index |
| req_addr | input | 8 | RF register address |
| req_wdata | input | 12 | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Read result (0 for writes and failed reads) |
| done_timeout | output | 1 | A polling phase ran out of budget |
| reg_rd_en | output | 1 | Register-port read strobe |
| reg_wr_en | output | 1 | Register-port write strobe |
| reg_sel | output | 1 | 0 = mailbox, 1 = data register |
| reg_wdata | output | 32 | Register-port write data |
| reg_rdata | input | 32 | Register-port read data, same cycle |

## Verification
A wrong retry count or gap timer shows up at the register port within one poll interval. It appears as a mailbox read that comes too early, or as a count of mailbox reads per request that differs from the value predicted by the responder's busy pattern. A fault in how the count is shared between the two phases of a read only becomes visible at the completion pulse. There, a read near the budget edge returns zero when data was due, or data when zero was due, and its timeout flag is wrong. A packing fault shows in the very cycle of the mailbox write.

// File: rtl/rfmb_pkg.sv
// Shared definitions for the RF command mailbox issuer.
// Assumes a 32-bit mailbox whose field positions are decoded by the
// controller that executes the commands, so the positions are fixed.
package rfmb_pkg;
    localparam int WORD_W   = 32;
    localparam int DATA_LSB = 0;
    localparam int DATA_W   = 12;
    localparam int ADDR_LSB = 12;
    localparam int ADDR_W   = 8;
    localparam int PATH_LSB = 20;
    localparam int PATH_W   = 2;
    localparam int DIR_BIT  = 22;
    localparam int TRIG_BIT = 31;

    typedef struct packed {
        logic              write;
        logic [PATH_W-1:0] path;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } rfmb_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_POLL,
        ST_PRE_WAIT,
        ST_ISSUE,
        ST_POST_POLL,
        ST_POST_WAIT,
        ST_FETCH
    } rfmb_state_e;
endpackage

// File: rtl/rfmb_cmd_pack.sv
// Packs a latched request into the mailbox command word.
// Assumes: purely combinational, and the trigger bit is always set.
module rfmb_cmd_pack
    import rfmb_pkg::*;
(
    input  rfmb_req_t          req,
    output logic [WORD_W-1:0]  word
);
    // Place every field at its decoded position and clear the unused bits.
    always_comb begin
        word                        = '0;
        word[DATA_LSB +: DATA_W]    = req.write ? req.wdata : '0;
        word[ADDR_LSB +: ADDR_W]    = req.addr;
        word[PATH_LSB +: PATH_W]    = req.path;
        word[DIR_BIT]               = req.write;
        word[TRIG_BIT]              = 1'b1;
    end
endmodule

// File: rtl/rfmb_poll_budget.sv
// Retry budget and inter-poll gap timer.
// Assumes: POLL_GAP >= 1; 'bump' marks a busy observation that still had
// budget, and restarts the gap timer; 'clear' starts a new request.
module rfmb_poll_budget #(
    parameter int POLL_LIMIT = 100,
    parameter int POLL_GAP   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic exhausted,
    output logic gap_done
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1) < 1 ? 1 : $clog2(POLL_LIMIT + 1);
    localparam int GAP_W = $clog2(POLL_GAP + 1) < 1 ? 1 : $clog2(POLL_GAP + 1);

    logic [CNT_W-1:0] retry_cnt;
    logic [GAP_W-1:0] gap_cnt;

    // Running retry count, shared by every polling phase of one request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) retry_cnt <= '0;
        else if (bump)       retry_cnt <= retry_cnt + 1'b1;
    end

    // Gap timer: restarts on each bump, saturates at POLL_GAP-1.
    always_ff @(posedge clk) begin
        if (!rst_n || bump)                          gap_cnt <= '0;
        else if (gap_cnt != GAP_W'(POLL_GAP - 1))    gap_cnt <= gap_cnt + 1'b1;
    end

    assign exhausted = (retry_cnt == CNT_W'(POLL_LIMIT));
    assign gap_done  = (gap_cnt == GAP_W'(POLL_GAP - 1));
endmodule

// File: rtl/rf_mbox_issuer.sv
// RF command mailbox issuer: polls the mailbox, issues one packed command,
// and for reads waits for completion and fetches the data register.
// Assumes: register-port read data is combinational and valid in the cycle
// of reg_rd_en; one request in flight; POLL_GAP given in clock cycles.
module rf_mbox_issuer
    import rfmb_pkg::*;
#(
    parameter int POLL_LIMIT = 100,
    parameter int POLL_GAP   = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [1:0]  req_path,
    input  logic [7:0]  req_addr,
    input  logic [11:0] req_wdata,
    output logic        done,
    output logic [31:0] done_rdata,
    output logic        done_timeout,
    output logic        reg_rd_en,
    output logic        reg_wr_en,
    output logic        reg_sel,
    output logic [31:0] reg_wdata,
    input  logic [31:0] reg_rdata
);
    rfmb_state_e       state;
    rfmb_req_t         req_q;
    logic              tmo_q;
    logic              take;
    logic              busy_seen;
    logic              bump;
    logic              exhausted;
    logic              gap_done;
    logic [WORD_W-1:0] cmd_word;

    assign take      = (state == ST_IDLE) && req_valid;
    assign busy_seen = reg_rdata[TRIG_BIT];
    assign bump      = ((state == ST_PRE_POLL) || (state == ST_POST_POLL))
                       && busy_seen && !exhausted;

    rfmb_cmd_pack u_pack (
        .req  (req_q),
        .word (cmd_word)
    );

    rfmb_poll_budget #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_GAP   (POLL_GAP)
    ) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take),
        .bump      (bump),
        .exhausted (exhausted),
        .gap_done  (gap_done)
    );

    // Register-port strobes decoded from the current state.
    always_comb begin
        reg_rd_en = (state == ST_PRE_POLL) || (state == ST_POST_POLL) || (state == ST_FETCH);
        reg_wr_en = (state == ST_ISSUE);
        reg_sel   = (state == ST_FETCH);
        reg_wdata = cmd_word;
    end

    assign req_ready = (state == ST_IDLE);

    // Sequencer: handshake, poll, issue, completion wait, result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            req_q        <= '0;
            tmo_q        <= 1'b0;
            done         <= 1'b0;
            done_rdata   <= '0;
            done_timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q <= '{write: req_write, path: req_path,
                                   addr: req_addr, wdata: req_wdata};
                        tmo_q <= 1'b0;
                        state <= ST_PRE_POLL;
                    end
                end
                ST_PRE_POLL: begin
                    if (!busy_seen) begin
                        state <= ST_ISSUE;
                    end else if (exhausted) begin
                        tmo_q <= 1'b1;
                        state <= ST_ISSUE;
                    end else begin
                        state <= ST_PRE_WAIT;
                    end
                end
                ST_PRE_WAIT: begin
                    if (gap_done) state <= ST_PRE_POLL;
                end
                ST_ISSUE: begin
                    if (req_q.write) begin
                        done         <= 1'b1;
                        done_rdata   <= '0;
                        done_timeout <= tmo_q;
                        state        <= ST_IDLE;
                    end else begin
                        state <= ST_POST_POLL;
                    end
                end
                ST_POST_POLL: begin
                    if (!busy_seen) begin
                        state <= ST_FETCH;
                    end else if (exhausted) begin
                        done         <= 1'b1;
                        done_rdata   <= '0;
                        done_timeout <= 1'b1;
                        state        <= ST_IDLE;
                    end else begin
                        state <= ST_POST_WAIT;
                    end
                end
                ST_POST_WAIT: begin
                    if (gap_done) state <= ST_POST_POLL;
                end
                ST_FETCH: begin
                    done         <= 1'b1;
                    done_rdata   <= reg_rdata;
                    done_timeout <= tmo_q;
                    state        <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rfmb_checker.sv
// Port-level protocol checks for rf_mbox_issuer, attached with bind.
// Assumes the same register-port timing as the issuer.
module rfmb_checker #(
    parameter int POLL_GAP = 1000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic        reg_rd_en,
    input logic        reg_wr_en,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata
);
    logic        busy_pending;
    logic [31:0] gap_seen;

    // Tracks the last mailbox busy observation and the cycles since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_pending <= 1'b0;
            gap_seen     <= '0;
        end else if (reg_rd_en && !reg_sel) begin
            busy_pending <= reg_rdata[31];
            gap_seen     <= '0;
        end else begin
            if (reg_wr_en || done) busy_pending <= 1'b0;
            if (gap_seen != '1)    gap_seen     <= gap_seen + 1'b1;
        end
    end

    a_r10_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en && reg_wr_en));

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_trigger_and_gap: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wdata[31] && (reg_wdata[30:23] == 8'h00) && !reg_sel));

    a_r3_read_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wdata[22]) |-> (reg_wdata[11:0] == 12'h000));

    a_r5_poll_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_sel && busy_pending) |-> (gap_seen >= 32'(POLL_GAP)));
endmodule

bind rf_mbox_issuer rfmb_checker #(.POLL_GAP(POLL_GAP)) u_rfmb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .reg_rd_en (reg_rd_en),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/rf_mbox_issuer_tb_top.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module rf_mbox_issuer_tb_top;
    localparam int L   = 5;
    localparam int GAP = 3;

    typedef struct packed {
        logic [31:0] word;
        logic [31:0] rdata;
        logic        tmo;
        logic [7:0]  nrd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_path = '0;
    logic [7:0]  req_addr = '0;
    logic [11:0] req_wdata = '0;
    logic        done;
    logic [31:0] done_rdata;
    logic        done_timeout;
    logic        reg_rd_en, reg_wr_en, reg_sel;
    logic [31:0] reg_wdata, reg_rdata;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    // Responder state
    logic [31:0] mbox_r = '0;
    logic [31:0] dreg = '0;
    int          cfg_pre = 0, cfg_post = 0;
    int          pre_seen = 0, post_seen = 0;
    logic        phase = 1'b0;
    logic        busy;

    // Monitor counters
    int nrd_mb = 0;
    int nwr = 0;

    always #5 clk = ~clk;

    rf_mbox_issuer #(.POLL_LIMIT(L), .POLL_GAP(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_path(req_path),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .done_rdata(done_rdata), .done_timeout(done_timeout),
        .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Controller stand-in: busy for a set number of polls before and after issue.
    assign busy      = phase ? (post_seen < cfg_post) : (pre_seen < cfg_pre);
    assign reg_rdata = reg_sel ? dreg : {busy, mbox_r[30:0]};

    always @(posedge clk) begin
        if (req_valid && req_ready) begin
            pre_seen  <= 0;
            post_seen <= 0;
            phase     <= 1'b0;
        end else begin
            if (reg_wr_en) begin
                mbox_r <= reg_wdata;
                phase  <= 1'b1;
            end
            if (reg_rd_en && !reg_sel) begin
                if (!phase) pre_seen  <= pre_seen + 1;
                else        post_seen <= post_seen + 1;
            end
        end
    end

    // Monitor: compares port activity against the queued expectations.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rd_en || reg_wr_en)
                check(!(reg_rd_en && reg_wr_en), "R10", {30'd0, reg_rd_en, reg_wr_en}, 32'd0);
            if (reg_rd_en && !reg_sel) nrd_mb++;
            if (reg_wr_en) begin
                nwr++;
                if (sb_q.size() > 0)
                    check(reg_wdata == sb_q[0].word, "R2/R3 word", reg_wdata, sb_q[0].word);
            end
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(done_rdata == e.rdata, "R7/R8 rdata", done_rdata, e.rdata);
                    check(done_timeout == e.tmo, "R6/R8 timeout", {31'd0, done_timeout}, {31'd0, e.tmo});
                    check(nrd_mb == int'(e.nrd), "R5 mailbox reads", nrd_mb, {24'd0, e.nrd});
                    check(nwr == 1, "R9 writes", nwr, 32'd1);
                end
                nrd_mb = 0;
                nwr    = 0;
            end
        end
    end

    task automatic run(input bit w, input logic [1:0] p, input logic [7:0] a,
                       input logic [11:0] d, input int pb, input int qb, input logic [31:0] dv);
        exp_t e;
        int   cnt;
        int   pre_rd;
        bit   give;
        e.word = {1'b1, 8'h00, w, p, a, (w ? d : 12'h000)};
        cnt    = (pb > L) ? L : pb;
        pre_rd = (pb > L) ? L + 1 : pb + 1;
        if (w) begin
            e.rdata = '0;
            e.tmo   = (pb > L);
            e.nrd   = 8'(pre_rd);
        end else begin
            give    = (qb > L - cnt);
            e.nrd   = 8'(pre_rd + (give ? (L - cnt + 1) : (qb + 1)));
            e.rdata = give ? 32'd0 : dv;
            e.tmo   = (pb > L) || give;
        end
        @(negedge clk);
        cfg_pre  = pb;
        cfg_post = qb;
        dreg     = dv;
        sb_q.push_back(e);
        req_valid = 1'b1;
        req_write = w;
        req_path  = p;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R4 ready low while busy", {31'd0, req_ready}, 32'd0);
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R9 done pulse length", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held and just after release
        check(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1 done", {31'd0, done}, 32'd0);
        check(!reg_rd_en && !reg_wr_en, "R1 strobes", {30'd0, reg_rd_en, reg_wr_en}, 32'd0);
        check(req_ready == 1'b1, "R1 ready after release", {31'd0, req_ready}, 32'd1);

        run(1'b1, 2'd1, 8'h3C, 12'h5A5, 0, 0, 32'h0);          // R2, R3 plain write
        run(1'b0, 2'd2, 8'h10, 12'hFFF, 0, 0, 32'h0000_0ABC);  // R3, R7 read, payload dropped
        run(1'b1, 2'd0, 8'h01, 12'h123, 2, 0, 32'h0);          // R5 busy before write
        run(1'b0, 2'd1, 8'h22, 12'h000, 1, 2, 32'h1234_5678);  // R5, R7 both phases busy
        run(1'b1, 2'd3, 8'h7E, 12'h0F0, 6, 0, 32'h0);          // R6 forced write
        run(1'b0, 2'd0, 8'h40, 12'h000, 6, 0, 32'hCAFE_0001);  // R7 forced read, data with flag
        run(1'b0, 2'd2, 8'h55, 12'h000, 2, 4, 32'hDEAD_BEEF);  // R8 shared budget runs out
        run(1'b0, 2'd2, 8'h56, 12'h000, 2, 3, 32'h0BAD_F00D);  // R8 boundary, just enough
        run(1'b0, 2'd1, 8'h05, 12'h000, 0, 5, 32'h0000_0777);  // R8 post phase uses full budget
        run(1'b0, 2'd1, 8'h06, 12'h000, 0, 6, 32'h0000_0888);  // R8 post phase one over
        run(1'b1, 2'd3, 8'hFF, 12'hFFF, 5, 0, 32'h0);          // R2, R6 all-ones fields, edge no force

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule